// File: doc/BRIEF.md
# Static Memory Bus Idle-Cycle Inserter

This block sits between the access request queue of a static memory bus controller and the strobe generator that drives the external pins. It compares each new access request against the last access that went out on the bus. When the pair could cause a conflict, it holds the request back for one automatic idle cycle. During that cycle every active-low control strobe is forced high.

Two pairings need an idle cycle. The first is any change of chip select, which keeps the outgoing device and the incoming device from driving the bus at the same time. The second is a read that follows a write to the same device, which lets the write finish before the read begins. The two rules merge: a pair that matches both still gets a single idle cycle. Any cycle in which the bus carries no access also counts as idle time, so a request that arrives after such a cycle starts at once.

The upstream side is a valid/ready stream. The rules for back-pressure are these:
- `req_ready` is low while the strobe generator reports an access in progress.
- `req_ready` is low during an inserted idle cycle.
- `req_ready` is combinational from the request fields. A request holds its fields stable until it is accepted.

A request transfers on a clock edge where `req_valid` and `req_ready` are both high. At that point `start_o` pulses to launch the access downstream.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset there is no previous access. `req_ready` is high when `acc_active` is low, `idle_o` is low, and the first request is accepted in the cycle it is presented.
- R2: A request whose chip select differs from the previous access is held for exactly one cycle, with `idle_o` high and `req_ready` low. It is accepted in the next cycle.
- R3: While `idle_o` is high, all six chip-select outputs, all four byte-select outputs, all four write-strobe outputs and the read strobe are high. Otherwise each output equals its raw input from the strobe generator.
- R4: A read (`req_wr`=0) that follows a write (`req_wr`=1) on the same chip select is held for exactly one idle cycle.
- R5: A read that follows a write on a different chip select gets one idle cycle in total, never two.
- R6: Read after read, write after write, and write after read on the same chip select are accepted with no idle cycle.
- R7: Any cycle with `acc_active` low and no transfer clears the previous-access record. The next request is then accepted with no idle cycle.
- R8: While `acc_active` is high, `req_ready`, `start_o` and `idle_o` are low, and the record is neither changed nor cleared.
- R9: A request with chip-select index 6 or 7 is consumed: `req_ready` is high and `start_o` stays low. It leaves the previous-access record unchanged.
- R10: On each accepted valid request, `start_o` is high in that same cycle, and `start_cs` and `start_wr` carry the request's chip select and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_cs | input | 3 | Requested chip-select index |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request can transfer this cycle |
| acc_active | input | 1 | Strobe generator busy with an access |
| start_o | output | 1 | Launch pulse for an accepted access |
| start_cs | output | 3 | Chip select of the launched access |
| start_wr | output | 1 | Direction of the launched access |
| idle_o | output | 1 | Inserted idle cycle in progress |
| ncs_raw | input | 6 | Chip-select strobes from the generator |
| nbs_raw | input | 4 | Byte-select strobes from the generator |
| nwr_raw | input | 4 | Write strobes from the generator |
| nrd_raw | input | 1 | Read strobe from the generator |
| ncs_o | output | 6 | Gated chip-select strobes, active low |
| nbs_o | output | 4 | Gated byte-select strobes, active low |
| nwr_o | output | 4 | Gated write strobes, active low |
| nrd_o | output | 1 | Gated read strobe, active low |

## Verification
A wrong previous-access record shows at the ports on the very next request. It appears either as a missing idle cycle, where `req_ready` is high where it should be low, or as an extra one, where `idle_o` is high on a pair that needs none. The bench sweeps every ordered pair of chip select and direction from a cleared record. It counts the idle cycles before acceptance and compares the count with the rule worked out from the pair. A record that survives a quiet cycle, or that is changed by a rejected index, shows up as a wrong count on the following request. Strobe gating faults show in the idle cycle itself.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

  // Conflict rule: a chip-select change, or a read landing after a write.
  function automatic logic gap_rule(input logic cs_differs, input dir_e prev_dir,
                                    input dir_e next_dir);
    return cs_differs || (prev_dir == DIR_WR && next_dir == DIR_RD);
  endfunction
endpackage

// File: rtl/idle_gap_history.sv
module idle_gap_history #(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            clear_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic            wr_i,
  output logic            vld_o,
  output logic [CS_W-1:0] cs_o,
  output logic            wr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      cs_o  <= '0;
      wr_o  <= 1'b0;
    end else if (load_i) begin
      vld_o <= 1'b1;
      cs_o  <= cs_i;
      wr_o  <= wr_i;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end
  end

  // R7
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !load_i) |=> !vld_o);
endmodule

// File: rtl/idle_gap_decide.sv
module idle_gap_decide
  import idle_gap_pkg::*;
#(
  parameter int N_CS = 6,
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_wr,
  input  logic            acc_active,
  input  logic            hist_vld,
  input  logic [CS_W-1:0] hist_cs,
  input  logic            hist_wr,
  output logic            req_ready,
  output logic            idle_o,
  output logic            start_o,
  output logic            hist_load,
  output logic            hist_clear
);
  logic cs_ok;
  logic gap_now;

  always_comb begin
    cs_ok      = int'(req_cs) < N_CS;
    gap_now    = req_valid && cs_ok && hist_vld &&
                 gap_rule(req_cs != hist_cs, dir_e'(hist_wr), dir_e'(req_wr));
    idle_o     = !acc_active && gap_now;
    req_ready  = !acc_active && !gap_now;
    start_o    = req_valid && req_ready && cs_ok;
    hist_load  = start_o;
    hist_clear = !acc_active && !(req_valid && req_ready);
  end

  // R2
  idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |=> !idle_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_active |-> (!req_ready && !start_o && !idle_o));
endmodule

// File: rtl/idle_gap_strobe_gate.sv
module idle_gap_strobe_gate #(
  parameter int N_CS = 6,
  parameter int N_BS = 4,
  parameter int N_WR = 4
) (
  input  logic            force_hi,
  input  logic [N_CS-1:0] ncs_raw,
  input  logic [N_BS-1:0] nbs_raw,
  input  logic [N_WR-1:0] nwr_raw,
  input  logic            nrd_raw,
  output logic [N_CS-1:0] ncs_o,
  output logic [N_BS-1:0] nbs_o,
  output logic [N_WR-1:0] nwr_o,
  output logic            nrd_o
);
  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    assign ncs_o[i] = ncs_raw[i] | force_hi;
  end
  for (genvar i = 0; i < N_BS; i++) begin : g_bs
    assign nbs_o[i] = nbs_raw[i] | force_hi;
  end
  for (genvar i = 0; i < N_WR; i++) begin : g_wr
    assign nwr_o[i] = nwr_raw[i] | force_hi;
  end
  assign nrd_o = nrd_raw | force_hi;
endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter #(
  parameter int N_CS = 6,
  parameter int N_BS = 4,
  parameter int N_WR = 4,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_wr,
  output logic            req_ready,
  input  logic            acc_active,
  output logic            start_o,
  output logic [CS_W-1:0] start_cs,
  output logic            start_wr,
  output logic            idle_o,
  input  logic [N_CS-1:0] ncs_raw,
  input  logic [N_BS-1:0] nbs_raw,
  input  logic [N_WR-1:0] nwr_raw,
  input  logic            nrd_raw,
  output logic [N_CS-1:0] ncs_o,
  output logic [N_BS-1:0] nbs_o,
  output logic [N_WR-1:0] nwr_o,
  output logic            nrd_o
);
  logic            hist_vld, hist_wr, hist_load, hist_clear;
  logic [CS_W-1:0] hist_cs;

  idle_gap_history #(.CS_W(CS_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .load_i(hist_load), .clear_i(hist_clear),
    .cs_i(req_cs), .wr_i(req_wr),
    .vld_o(hist_vld), .cs_o(hist_cs), .wr_o(hist_wr)
  );

  idle_gap_decide #(.N_CS(N_CS), .CS_W(CS_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_wr(req_wr), .acc_active(acc_active),
    .hist_vld(hist_vld), .hist_cs(hist_cs), .hist_wr(hist_wr),
    .req_ready(req_ready), .idle_o(idle_o), .start_o(start_o),
    .hist_load(hist_load), .hist_clear(hist_clear)
  );

  idle_gap_strobe_gate #(.N_CS(N_CS), .N_BS(N_BS), .N_WR(N_WR)) u_gate (
    .force_hi(idle_o), .ncs_raw(ncs_raw), .nbs_raw(nbs_raw),
    .nwr_raw(nwr_raw), .nrd_raw(nrd_raw),
    .ncs_o(ncs_o), .nbs_o(nbs_o), .nwr_o(nwr_o), .nrd_o(nrd_o)
  );

  assign start_cs = req_cs;
  assign start_wr = req_wr;

  // R3
  strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (&ncs_o && &nbs_o && &nwr_o && nrd_o));

  // R2
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(start_o)) |->
      (start_cs == $past(start_cs) && !($past(start_wr) && !start_wr)));

  // R9
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_cs) >= N_CS) |-> !start_o);
endmodule

// File: tb/idle_gap_inserter_bench.sv
module idle_gap_inserter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, acc_active = 1'b0;
  logic [2:0] req_cs = '0;
  logic req_ready, start_o, start_wr, idle_o, nrd_o;
  logic [2:0] start_cs;
  logic [5:0] ncs_raw = '1, ncs_o;
  logic [3:0] nbs_raw = '1, nbs_o, nwr_raw = '1, nwr_o;
  logic nrd_raw = 1'b1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  idle_gap_inserter u_idle_gap_inserter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_wr(req_wr), .req_ready(req_ready), .acc_active(acc_active),
    .start_o(start_o), .start_cs(start_cs), .start_wr(start_wr),
    .idle_o(idle_o), .ncs_raw(ncs_raw), .nbs_raw(nbs_raw),
    .nwr_raw(nwr_raw), .nrd_raw(nrd_raw), .ncs_o(ncs_o), .nbs_o(nbs_o),
    .nwr_o(nwr_o), .nrd_o(nrd_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // Presents a request and returns the number of idle cycles before acceptance.
  task automatic send(input int cs, input bit wr, output int n_idle);
    n_idle = 0;
    req_valid = 1'b1;
    req_cs = 3'(cs);
    req_wr = wr;
    ncs_raw = 6'b0; nbs_raw = 4'b0; nwr_raw = 4'b0; nrd_raw = 1'b0;
    #1;
    while (!req_ready && n_idle < 4) begin
      if (idle_o) begin
        n_idle++;
        chk("R3 strobes high in idle", {ncs_o, nbs_o, nwr_o, nrd_o}, 15'h7fff);
      end
      @(negedge clk);
      #1;
    end
    chk("R3 pass-through", {ncs_o, nbs_o, nwr_o, nrd_o}, 0);
    if (cs < 6) begin
      chk("R10 start", start_o, 1);
      chk("R10 cs", start_cs, cs);
      chk("R10 wr", start_wr, wr);
    end else begin
      chk("R9 ready for bad index", req_ready, 1);
      chk("R9 no start", start_o, 0);
    end
    ncs_raw = '1; nbs_raw = '1; nwr_raw = '1; nrd_raw = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 idle low after reset", idle_o, 0);
    @(negedge clk);
    send(3, 1'b0, n);
    chk("R1 first access no gap", n, 0);

    for (int pc = 0; pc < 6; pc++)
      for (int pw = 0; pw < 2; pw++)
        for (int nc = 0; nc < 6; nc++)
          for (int nw = 0; nw < 2; nw++) begin
            int exp;
            quiet();
            send(pc, pw[0], n);
            chk("R7 quiet cycle clears record", n, 0);
            send(nc, nw[0], n);
            exp = (pc != nc || (pw == 1 && nw == 0)) ? 1 : 0;
            if (pc != nc) chk("R2/R5 chip-select change", n, exp);
            else if (pw == 1 && nw == 0) chk("R4 write then read", n, exp);
            else chk("R6 no gap same cs", n, exp);
          end

    // R8: a busy strobe generator holds everything off and keeps the record
    quiet();
    send(1, 1'b1, n);
    acc_active = 1'b1;
    req_valid = 1'b1; req_cs = 3'd1; req_wr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 ready low while busy", req_ready, 0);
      chk("R8 no start while busy", start_o, 0);
      chk("R8 no idle while busy", idle_o, 0);
      @(negedge clk);
    end
    acc_active = 1'b0;
    send(1, 1'b0, n);
    chk("R8 record kept while busy", n, 1);

    // R9: rejected index leaves the record alone
    quiet();
    send(0, 1'b0, n);
    send(7, 1'b1, n);
    send(1, 1'b0, n);
    chk("R9 record kept after bad index", n, 1);
    quiet();
    send(2, 1'b1, n);
    send(6, 1'b0, n);
    send(2, 1'b0, n);
    chk("R9 write record kept after bad index", n, 1);

    quiet();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule